// File: doc/BRIEF.md
# Wait-Instruction Virtualization Controller

This block decides what happens when a guest core issues a monitor-wait style instruction while it runs under hardware virtualization. It also sequences the core into and out of the low-power wait that follows. The core presents one request per instruction together with the state that governs the outcome:

- the current privilege level;
- the control bit that forces a VM exit on wait;
- the control bit that arms interrupt-window exiting;
- the flag for a pending virtual interrupt;
- bit 0 of the instruction's extension register (wake even when interrupts are masked);
- the interrupt-enable flag.

The block answers with exactly one registered one-cycle verdict pulse: invalid-opcode fault, VM exit, enter-wait or fall-through.

A verdict is chosen by priority. A privilege fault wins over a VM exit, and a VM exit wins over the choice between sleeping and falling through. Falling through happens only in one case. Interrupts must be masked and wake-on-interrupt requested, and then either an interrupt window must be armed or a virtual interrupt must be pending. The instruction then completes as a no-op.

The sequencer has three states: IDLE, WAIT and RESUME. The transitions are:

- accept_sleep (IDLE to WAIT), taken on an enter-wait verdict;
- wake (WAIT to RESUME), taken on a wake event;
- resume_done (RESUME to IDLE), taken unconditionally after one cycle.

The sleeping output is high in WAIT and the resume strobe is high in RESUME. Requests are accepted only in IDLE.

Top module: `wait_virt_ctrl`

## Requirements
- R1: An accepted request with privilege level not equal to 0 produces `fault_ud` in the cycle after the request, and no other verdict, whatever the control bits.
- R2: At privilege 0 with `wait_exit_en`=1, an accepted request produces `vm_exit` alone.
- R3: At privilege 0 with `wait_exit_en`=0 and `ext_hint`=0, the request produces `wait_enter`.
- R4: At privilege 0 with `wait_exit_en`=0 and `int_enable`=1, the request produces `wait_enter`.
- R5: At privilege 0 with `wait_exit_en`=0, `intwin_exit_en`=0 and `virq_pending`=0, the request produces `wait_enter`.
- R6: At privilege 0 with `wait_exit_en`=0, `ext_hint`=1 and `int_enable`=0, the request produces `fall_through` if `intwin_exit_en` or `virq_pending` is 1, and the block stays in IDLE.
- R7: The verdict outputs are registered and mutually exclusive. Each accepted request gives exactly one of them for exactly one cycle, and none is asserted without an accepted request.
- R8: `sleeping` rises in the same cycle as `wait_enter`. It stays high until the cycle after a `wake_evt` is sampled in WAIT, and then falls.
- R9: `resume_strobe` is high for exactly the one cycle after `sleeping` falls, and the block then returns to IDLE.
- R10: A request presented while `sleeping` or `resume_strobe` is high is ignored: no verdict follows it.
- R11: After reset all outputs are 0 and the block is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Wait instruction issued this cycle |
| priv_lvl | input | PRIV_W | Current privilege level |
| wait_exit_en | input | 1 | Control: wait causes a VM exit |
| intwin_exit_en | input | 1 | Control: interrupt-window exiting armed |
| virq_pending | input | 1 | A virtual interrupt is recognized as pending |
| ext_hint | input | 1 | Extension register bit 0 (wake on masked interrupt) |
| int_enable | input | 1 | Interrupt-enable flag |
| wake_evt | input | 1 | Wake event while sleeping |
| fault_ud | output | 1 | Invalid-opcode fault pulse |
| vm_exit | output | 1 | VM exit pulse |
| wait_enter | output | 1 | Enter-wait pulse |
| fall_through | output | 1 | Continue-with-next-instruction pulse |
| sleeping | output | 1 | Core is in the wait |
| resume_strobe | output | 1 | One-cycle strobe on leaving the wait |

## Verification
Every combination of all four privilege levels and the five control and flag inputs is applied as a request from IDLE. This sweep tells the fault, VM-exit, enter and fall-through cases apart and checks that each case gives exactly one pulse. Every combination that enters the wait is then given a stray request while sleeping, to show that the request is ignored. It is also given a delayed wake, to check that sleeping holds until the wake and that the resume strobe follows it. Requests issued back to back in IDLE show that a fall-through leaves the block free to accept the next request at once.

// File: rtl/wait_pkg.sv
package wait_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_RESUME = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        V_FAULT = 2'd0,
        V_EXIT  = 2'd1,
        V_ENTER = 2'd2,
        V_FALL  = 2'd3
    } verdict_e;
endpackage

// File: rtl/wait_decode.sv
module wait_decode #(
    parameter int PRIV_W = 2
) (
    input  logic [PRIV_W-1:0] priv_lvl,
    input  logic              wait_exit_en,
    input  logic              intwin_exit_en,
    input  logic              virq_pending,
    input  logic              ext_hint,
    input  logic              int_enable,
    output wait_pkg::verdict_e verdict
);
    import wait_pkg::*;

    logic privileged_ok;
    logic sleep_allowed;

    assign privileged_ok = (priv_lvl == '0);
    // Sleep proceeds unless masked wake-on-interrupt meets an interrupt
    // that would end it at once.
    assign sleep_allowed = !ext_hint || int_enable
                           || (!intwin_exit_en && !virq_pending);

    always_comb begin
        if (!privileged_ok)      verdict = V_FAULT;
        else if (wait_exit_en)   verdict = V_EXIT;
        else if (sleep_allowed)  verdict = V_ENTER;
        else                     verdict = V_FALL;
    end
endmodule

// File: rtl/wait_seq.sv
module wait_seq (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  wait_pkg::verdict_e verdict,
    input  logic               wake_evt,
    output logic               ready,
    output logic               fault_ud,
    output logic               vm_exit,
    output logic               wait_enter,
    output logic               fall_through,
    output logic               sleeping,
    output logic               resume_strobe
);
    import wait_pkg::*;

    seq_state_e state, state_nx;
    logic       accept;

    assign ready  = (state == ST_IDLE);
    assign accept = req_valid && ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: accept_sleep, wake, resume_done
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept && verdict == V_ENTER) state_nx = ST_WAIT;
            ST_WAIT:   if (wake_evt) state_nx = ST_RESUME;
            ST_RESUME: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Output process: registered verdict pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_ud     <= 1'b0;
            vm_exit      <= 1'b0;
            wait_enter   <= 1'b0;
            fall_through <= 1'b0;
        end else begin
            fault_ud     <= accept && (verdict == V_FAULT);
            vm_exit      <= accept && (verdict == V_EXIT);
            wait_enter   <= accept && (verdict == V_ENTER);
            fall_through <= accept && (verdict == V_FALL);
        end
    end

    assign sleeping      = (state == ST_WAIT);
    assign resume_strobe = (state == ST_RESUME);

    p_one_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_ud, vm_exit, wait_enter, fall_through}));
    p_pulse_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ($countones({fault_ud, vm_exit, wait_enter, fall_through}) == 1));
    p_sleep_with_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_enter) |-> sleeping);
    p_sleep_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && !wake_evt) |=> sleeping);
    p_resume_after_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && wake_evt) |=> (resume_strobe && !sleeping));
    p_resume_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resume_strobe |=> !resume_strobe);
    p_busy_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ready) |=> !(fault_ud || vm_exit || wait_enter || fall_through));
endmodule

// File: rtl/wait_virt_ctrl.sv
module wait_virt_ctrl #(
    parameter int PRIV_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PRIV_W-1:0] priv_lvl,
    input  logic              wait_exit_en,
    input  logic              intwin_exit_en,
    input  logic              virq_pending,
    input  logic              ext_hint,
    input  logic              int_enable,
    input  logic              wake_evt,
    output logic              fault_ud,
    output logic              vm_exit,
    output logic              wait_enter,
    output logic              fall_through,
    output logic              sleeping,
    output logic              resume_strobe
);
    wait_pkg::verdict_e verdict;
    logic               ready;

    wait_decode #(.PRIV_W(PRIV_W)) u_decode (
        .priv_lvl       (priv_lvl),
        .wait_exit_en   (wait_exit_en),
        .intwin_exit_en (intwin_exit_en),
        .virq_pending   (virq_pending),
        .ext_hint       (ext_hint),
        .int_enable     (int_enable),
        .verdict        (verdict)
    );

    wait_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .verdict       (verdict),
        .wake_evt      (wake_evt),
        .ready         (ready),
        .fault_ud      (fault_ud),
        .vm_exit       (vm_exit),
        .wait_enter    (wait_enter),
        .fall_through  (fall_through),
        .sleeping      (sleeping),
        .resume_strobe (resume_strobe)
    );

    p_priv_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready && priv_lvl != '0) |=> fault_ud);
    p_exit_priority_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready && priv_lvl == '0 && wait_exit_en) |=> vm_exit);
    p_masked_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready && priv_lvl == '0 && !wait_exit_en && ext_hint
         && !int_enable && (intwin_exit_en || virq_pending)) |=> (fall_through && !sleeping));
endmodule

// File: tb/wait_virt_ctrl_test.sv
`timescale 1ns/1ps
module wait_virt_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] priv_lvl = '0;
    logic       wait_exit_en = 1'b0, intwin_exit_en = 1'b0, virq_pending = 1'b0;
    logic       ext_hint = 1'b0, int_enable = 1'b0, wake_evt = 1'b0;
    logic       fault_ud, vm_exit, wait_enter, fall_through, sleeping, resume_strobe;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    wait_virt_ctrl #(.PRIV_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .priv_lvl(priv_lvl),
        .wait_exit_en(wait_exit_en), .intwin_exit_en(intwin_exit_en),
        .virq_pending(virq_pending), .ext_hint(ext_hint), .int_enable(int_enable),
        .wake_evt(wake_evt), .fault_ud(fault_ud), .vm_exit(vm_exit),
        .wait_enter(wait_enter), .fall_through(fall_through),
        .sleeping(sleeping), .resume_strobe(resume_strobe)
    );

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (fault,exit,enter,fall,sleep,resume)",
                     tag, act, exp);
        end
    endtask

    function automatic logic [5:0] outs();
        return {fault_ud, vm_exit, wait_enter, fall_through, sleeping, resume_strobe};
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [1:0] p, input logic [4:0] f);
        priv_lvl = p;
        {wait_exit_en, intwin_exit_en, virq_pending, ext_hint, int_enable} = f;
    endtask

    function automatic logic [3:0] expect_v(input logic [1:0] p, input logic [4:0] f);
        logic wx, iw, vp, ex, ie;
        {wx, iw, vp, ex, ie} = f;
        if (p != 0) return 4'b1000;
        if (wx)     return 4'b0100;
        if (!ex || ie || (!iw && !vp)) return 4'b0010;
        return 4'b0001;
    endfunction

    function automatic string tag_of(input logic [3:0] v, input logic [4:0] f);
        if (v[3]) return "R1";
        if (v[2]) return "R2";
        if (v[0]) return "R6";
        if (!f[1]) return "R3";
        if (f[0])  return "R4";
        return "R5";
    endfunction

    initial begin
        @(negedge clk);
        step();
        check("R11 reset", outs(), 6'b000000);
        rst_n = 1'b1;
        step();
        check("R11 idle after reset", outs(), 6'b000000);

        for (int p = 0; p < 4; p++) begin
            for (int f = 0; f < 32; f++) begin
                logic [3:0] ev;
                ev = expect_v(2'(p), 5'(f));
                drive(2'(p), 5'(f));
                req_valid = 1'b1;
                step();
                req_valid = 1'b0;
                check({tag_of(ev, 5'(f)), " verdict R7"}, outs(), {ev, ev[1], 1'b0});
                step();
                check("R7 pulse is single", outs(), {4'b0000, ev[1], 1'b0});
                if (ev[1]) begin
                    // R10: a stray request while asleep is ignored
                    drive(2'd0, 5'b00000);
                    req_valid = 1'b1;
                    step();
                    req_valid = 1'b0;
                    check("R10 request while sleeping", outs(), 6'b000010);
                    step();
                    check("R8 sleep held", outs(), 6'b000010);
                    wake_evt = 1'b1;
                    step();
                    wake_evt = 1'b0;
                    check("R9 resume strobe", outs(), 6'b000001);
                    // R10: a request during resume is ignored
                    req_valid = 1'b1;
                    step();
                    req_valid = 1'b0;
                    check("R9 back to idle", outs(), 6'b000000);
                    step();
                    check("R10 request in resume ignored", outs(), 6'b000000);
                end
            end
        end

        // R6 back-to-back: a fall-through leaves IDLE ready for the next request
        drive(2'd0, 5'b01010);
        req_valid = 1'b1;
        step();
        check("R6 first fall", outs(), 6'b000100);
        drive(2'd0, 5'b10000);
        step();
        req_valid = 1'b0;
        check("R2 following exit", outs(), 6'b010000);
        step();
        check("R7 quiet without request", outs(), 6'b000000);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule